// File: doc/BRIEF.md
# Instruction-Cycle Interrupt Request Unit

This block decides when a small 8-bit core, which spends four clock phases on each instruction cycle, must break its program flow to service an interrupt. It keeps three 8-bit registers that software reaches over a simple read and write port: a core control register, a peripheral flag register and a peripheral enable register. Hardware events set the flags. They come from an external pin with a selectable edge, a timer overflow pulse, a port-change pulse and eight peripheral pulses. Each flag stays set until software writes a zero to it.

Each flag is ANDed with its enable and the results are gated by the global and peripheral enables. The combined request is sampled once per instruction cycle, on the clock in which the core reports phase 1. When the request is taken, the unit clears the global enable and presents the return address (current PC plus one) with a one-clock push strobe for the stack. It then marks two instruction cycles as dummy cycles. During the second of these it tells the core to fetch from the fixed vector. A return pulse from the core sets the global enable again.

The register port is plain control: writes take effect on the clock edge and reads are combinational. The port has no back-pressure, so no valid/ready handshake applies.

Top module: `irq_ctrl_unit`

## Requirements
- R1: After reset all three registers read 0x00, and `irq_ack_o`, `dummy_o` and `vec_fetch_o` are low.
- R2: Register address 0 selects the control register, 1 the peripheral flag register and 2 the peripheral enable register, and a written value reads back unchanged. Address 3 reads 0x00. Control bits from 7 to 0: global enable, peripheral enable, timer enable, pin enable, port-change enable, timer flag, pin flag, port-change flag.
- R3: Flags are sticky. A software write of 0 clears a flag. A hardware set in the same clock as that write wins, and the flag stays 1.
- R4: With `ext_rise_sel_i`=1 a rising pin edge sets control bit 1, and with 0 a falling edge sets it. An edge of the other polarity has no effect. The bit only changes on a clock where `ph_i` is 3 (phase 4) or 0 (phase 1). An edge seen in another phase waits for that window.
- R5: `irq_req_o` is high only when the global enable is set and either a control flag bit n (n=0..2) meets enable bit n+3, or the peripheral enable is set and some peripheral flag bit meets the matching peripheral enable bit.
- R6: The request is sampled only at clock edges where `ph_i`=0. A taken request gives a one-clock `irq_ack_o` after that edge, with `ret_pc_o` = `pc_i`+1 (modulo the PC width). The global enable reads 0 from then on.
- R7: After a take, `dummy_o` is high for exactly the next two instruction cycles (8 clocks), starting at the following phase-1 edge. `vec_fetch_o` is high for the second one (4 clocks) with `vec_addr_o` = 0x0004.
- R8: A one-clock `reti_i` pulse sets the global enable.
- R9: Bit n of `per_evt_i` sets bit n of the peripheral flag register. Both peripheral registers use this bit order from 7 to 0: EEPROM, ADC, UART receive, comparator 2, comparator 1, oscillator fail, UART transmit, timer 1.
- R10: `tmr_ovf_i` sets control bit 2 and `port_chg_i` sets control bit 0, whether or not their enables are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, four per instruction cycle |
| rst_n | input | 1 | Active-low reset |
| ph_i | input | 2 | Current phase, 0 = phase 1 ... 3 = phase 4 |
| bus_wr_i | input | 1 | Register write strobe |
| bus_waddr_i | input | 2 | Write register select |
| bus_wdata_i | input | 8 | Write data |
| bus_raddr_i | input | 2 | Read register select |
| bus_rdata_o | output | 8 | Read data (combinational) |
| ext_pin_i | input | 1 | Asynchronous external interrupt pin |
| ext_rise_sel_i | input | 1 | 1 = rising edge, 0 = falling edge |
| tmr_ovf_i | input | 1 | Timer overflow pulse |
| port_chg_i | input | 1 | Port-change pulse |
| per_evt_i | input | 8 | Peripheral event pulses |
| pc_i | input | 13 | PC of the instruction being executed |
| reti_i | input | 1 | Return-from-interrupt pulse |
| irq_req_o | output | 1 | Combined interrupt request |
| irq_ack_o | output | 1 | Interrupt taken, push strobe |
| ret_pc_o | output | 13 | Return address to push |
| dummy_o | output | 1 | Current instruction cycle is a dummy cycle |
| vec_fetch_o | output | 1 | Fetch from the vector this cycle |
| vec_addr_o | output | 13 | Vector address |

## Verification
The bench clears a flag with a software write in the same clock as a hardware pulse on that flag. A design that lets the write win would lose the event. It also drives pin edges at arbitrary phases and records the phase in which the pin flag first appears. A design without the phase 4 / phase 1 window would show the flag in phases 2 or 3. A design that dropped out-of-window edges would never show it. The bench tries the wrong pin polarity, and a peripheral match while the peripheral enable is off. Any acknowledge that these cases raise is unexpected and shows up as a scoreboard miss. It counts dummy and vector-fetch clocks, which exposes an off-by-one-cycle sequencer. The return address is checked at the top of the PC range so that a missing modulo wrap is caught.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    RA_CTRL  = 2'd0,
    RA_PFLAG = 2'd1,
    RA_PEN   = 2'd2,
    RA_NONE  = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_ARMED  = 2'd1,
    SQ_DUMMY1 = 2'd2,
    SQ_DUMMY2 = 2'd3
  } seq_e;

  // control register bit positions (enable n+3 pairs with flag n)
  localparam int B_GIE  = 7;
  localparam int B_PEIE = 6;
  localparam int B_TIE  = 5;
  localparam int B_XIE  = 4;
  localparam int B_PCIE = 3;
  localparam int B_TIF  = 2;
  localparam int B_XIF  = 1;
  localparam int B_PCIF = 0;
  localparam int CORE_SRCS = 3;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic rise_sel_i,
  output logic edge_o
);
  localparam int LAST = STAGES - 1;

  // STAGES synchronizer flops plus one history flop
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  always_comb begin
    if (rise_sel_i) edge_o = sh_q[LAST] & ~sh_q[STAGES];
    else            edge_o = ~sh_q[LAST] & sh_q[STAGES];
  end
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [1:0]       waddr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [1:0]       raddr_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic [REG_W-1:0] ctrl_set_i,
  input  logic [REG_W-1:0] pflag_set_i,
  input  logic             gie_set_i,
  input  logic             gie_clr_i,
  output logic [REG_W-1:0] ctrl_o,
  output logic [REG_W-1:0] pflag_o,
  output logic [REG_W-1:0] pen_o
);
  logic [REG_W-1:0] ctrl_q, pflag_q, pen_q;
  logic [REG_W-1:0] ctrl_d, pflag_d, pen_d;

  always_comb begin
    ctrl_d  = (wr_i && waddr_i == RA_CTRL)  ? wdata_i : ctrl_q;
    pflag_d = (wr_i && waddr_i == RA_PFLAG) ? wdata_i : pflag_q;
    pen_d   = (wr_i && waddr_i == RA_PEN)   ? wdata_i : pen_q;
    // hardware sets win over a software clear in the same clock
    ctrl_d  = ctrl_d | ctrl_set_i;
    pflag_d = pflag_d | pflag_set_i;
    if (gie_set_i) ctrl_d[B_GIE] = 1'b1;
    if (gie_clr_i) ctrl_d[B_GIE] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      pflag_q <= '0;
      pen_q   <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      pflag_q <= pflag_d;
      pen_q   <= pen_d;
    end
  end

  always_comb begin
    unique case (raddr_i)
      RA_CTRL:  rdata_o = ctrl_q;
      RA_PFLAG: rdata_o = pflag_q;
      RA_PEN:   rdata_o = pen_q;
      default:  rdata_o = '0;
    endcase
  end

  assign ctrl_o  = ctrl_q;
  assign pflag_o = pflag_q;
  assign pen_o   = pen_q;

  AST_PFLAG_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (|pflag_set_i) |=> ((pflag_q & $past(pflag_set_i)) == $past(pflag_set_i))); // R3
  AST_CTRL_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (|ctrl_set_i) |=> ((ctrl_q & $past(ctrl_set_i)) == $past(ctrl_set_i))); // R10
  AST_RETI_SETS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    (gie_set_i && !gie_clr_i) |=> ctrl_q[B_GIE]); // R8
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_pkg::*;
#(
  parameter int          PCW    = 13,
  parameter logic [PCW-1:0] VEC = 'h4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       ph_i,
  input  logic [REG_W-1:0] ctrl_i,
  input  logic [REG_W-1:0] pflag_i,
  input  logic [REG_W-1:0] pen_i,
  input  logic [PCW-1:0]   pc_i,
  output logic             req_o,
  output logic             take_o,
  output logic             ack_o,
  output logic [PCW-1:0]   ret_pc_o,
  output logic             dummy_o,
  output logic             vec_fetch_o,
  output logic [PCW-1:0]   vec_addr_o
);
  localparam logic [PCW-1:0] PC_ONE = PCW'(1);

  seq_e           state_q;
  logic           ack_q;
  logic [PCW-1:0] ret_q;
  logic           core_hit, per_hit, sample;

  always_comb begin
    core_hit = |(ctrl_i[B_PCIE +: CORE_SRCS] & ctrl_i[B_PCIF +: CORE_SRCS]);
    per_hit  = ctrl_i[B_PEIE] & (|(pflag_i & pen_i));
    req_o    = ctrl_i[B_GIE] & (core_hit | per_hit);
    sample   = (ph_i == PH_Q1);
    take_o   = sample & req_o & (state_q == SQ_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      ack_q   <= 1'b0;
      ret_q   <= '0;
    end else begin
      ack_q <= take_o;
      if (take_o) ret_q <= pc_i + PC_ONE;
      if (sample) begin
        unique case (state_q)
          SQ_IDLE:   if (take_o) state_q <= SQ_ARMED;
          SQ_ARMED:  state_q <= SQ_DUMMY1;
          SQ_DUMMY1: state_q <= SQ_DUMMY2;
          default:   state_q <= SQ_IDLE;
        endcase
      end
    end
  end

  assign ack_o       = ack_q;
  assign ret_pc_o    = ret_q;
  assign dummy_o     = (state_q == SQ_DUMMY1) || (state_q == SQ_DUMMY2);
  assign vec_fetch_o = (state_q == SQ_DUMMY2);
  assign vec_addr_o  = VEC;

  AST_ACK_AFTER_Q1: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> ($past(ph_i) == PH_Q1)); // R6
  AST_SEQ_ONLY_ON_Q1: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_i != PH_Q1) |=> $stable(state_q)); // R6
  AST_VEC_IN_DUMMY: assert property (@(posedge clk) disable iff (!rst_n)
    vec_fetch_o |-> dummy_o); // R7
endmodule

// File: rtl/irq_ctrl_unit.sv
module irq_ctrl_unit
  import irq_pkg::*;
#(
  parameter int PCW         = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       ph_i,
  input  logic             bus_wr_i,
  input  logic [1:0]       bus_waddr_i,
  input  logic [REG_W-1:0] bus_wdata_i,
  input  logic [1:0]       bus_raddr_i,
  output logic [REG_W-1:0] bus_rdata_o,
  input  logic             ext_pin_i,
  input  logic             ext_rise_sel_i,
  input  logic             tmr_ovf_i,
  input  logic             port_chg_i,
  input  logic [REG_W-1:0] per_evt_i,
  input  logic [PCW-1:0]   pc_i,
  input  logic             reti_i,
  output logic             irq_req_o,
  output logic             irq_ack_o,
  output logic [PCW-1:0]   ret_pc_o,
  output logic             dummy_o,
  output logic             vec_fetch_o,
  output logic [PCW-1:0]   vec_addr_o
);
  localparam logic [PCW-1:0] VEC_ADDR = PCW'(4);

  logic             pin_edge, pend_q, in_window, ext_set, take;
  logic [REG_W-1:0] ctrl, pflag, pen, ctrl_set;

  irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_i      (ext_pin_i),
    .rise_sel_i (ext_rise_sel_i),
    .edge_o     (pin_edge)
  );

  // the pin flag may only change in the phase 4 / phase 1 window
  assign in_window = (ph_i == PH_Q4) || (ph_i == PH_Q1);
  assign ext_set   = (pend_q | pin_edge) & in_window;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= (pend_q | pin_edge) & ~in_window;
  end

  always_comb begin
    ctrl_set         = '0;
    ctrl_set[B_TIF]  = tmr_ovf_i;
    ctrl_set[B_XIF]  = ext_set;
    ctrl_set[B_PCIF] = port_chg_i;
  end

  irq_regfile u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_i        (bus_wr_i),
    .waddr_i     (bus_waddr_i),
    .wdata_i     (bus_wdata_i),
    .raddr_i     (bus_raddr_i),
    .rdata_o     (bus_rdata_o),
    .ctrl_set_i  (ctrl_set),
    .pflag_set_i (per_evt_i),
    .gie_set_i   (reti_i),
    .gie_clr_i   (take),
    .ctrl_o      (ctrl),
    .pflag_o     (pflag),
    .pen_o       (pen)
  );

  irq_seq #(.PCW(PCW), .VEC(VEC_ADDR)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .ph_i        (ph_i),
    .ctrl_i      (ctrl),
    .pflag_i     (pflag),
    .pen_i       (pen),
    .pc_i        (pc_i),
    .req_o       (irq_req_o),
    .take_o      (take),
    .ack_o       (irq_ack_o),
    .ret_pc_o    (ret_pc_o),
    .dummy_o     (dummy_o),
    .vec_fetch_o (vec_fetch_o),
    .vec_addr_o  (vec_addr_o)
  );

  AST_XFLAG_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ctrl[B_XIF]) && !$past(bus_wr_i && bus_waddr_i == RA_CTRL))
      |-> ($past(ph_i) == PH_Q4 || $past(ph_i) == PH_Q1)); // R4
  AST_GIE_OFF_AT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack_o |-> !ctrl[B_GIE]); // R6
  AST_NO_ACK_WITHOUT_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ctrl[B_GIE]) |-> !irq_ack_o); // R5
endmodule

// File: tb/irq_ctrl_unit_tb_top.sv
`timescale 1ns/1ps
module irq_ctrl_unit_tb_top;
  localparam int PCW = 13;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [1:0]     ph = 2'd0;
  logic           wr = 1'b0;
  logic [1:0]     waddr = '0;
  logic [7:0]     wdata = '0;
  logic [1:0]     raddr = '0;
  logic [7:0]     rdata;
  logic           pin = 1'b0;
  logic           rise_sel = 1'b1;
  logic           tmr = 1'b0;
  logic           pchg = 1'b0;
  logic [7:0]     pev = '0;
  logic [PCW-1:0] pc = '0;
  logic           reti = 1'b0;
  logic           req, ack, dummy, vfetch;
  logic [PCW-1:0] ret_pc, vaddr;

  int n_tests = 0;
  int n_fail  = 0;
  int n_ack = 0, n_dummy = 0, n_vec = 0;
  logic [PCW-1:0] exp_q[$];
  bit done = 0;

  always #5 clk = ~clk;
  always @(negedge clk) ph <= ph + 2'd1;

  irq_ctrl_unit dut_i (
    .clk(clk), .rst_n(rst_n), .ph_i(ph),
    .bus_wr_i(wr), .bus_waddr_i(waddr), .bus_wdata_i(wdata),
    .bus_raddr_i(raddr), .bus_rdata_o(rdata),
    .ext_pin_i(pin), .ext_rise_sel_i(rise_sel),
    .tmr_ovf_i(tmr), .port_chg_i(pchg), .per_evt_i(pev),
    .pc_i(pc), .reti_i(reti),
    .irq_req_o(req), .irq_ack_o(ack), .ret_pc_o(ret_pc),
    .dummy_o(dummy), .vec_fetch_o(vfetch), .vec_addr_o(vaddr)
  );

  task automatic check(input string req_s, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req_s, act, exp);
    end
  endtask

  // monitor: scoreboard pop on every acknowledge, event counters
  always @(negedge clk) begin
    if (rst_n) begin
      if (dummy)  n_dummy++;
      if (vfetch) begin
        n_vec++;
        if (vaddr !== 13'h0004) begin
          n_tests++; n_fail++;
          $display("FAIL R7: vector actual 0x%0h expected 0x4", vaddr);
        end
      end
      if (ack) begin
        n_ack++;
        n_tests++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R5/R6: unexpected ack, actual 1 expected 0");
        end else begin
          logic [PCW-1:0] e;
          e = exp_q.pop_front();
          if (ret_pc !== e) begin
            n_fail++;
            $display("FAIL R6: ret_pc actual 0x%0h expected 0x%0h", ret_pc, e);
          end
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wr = 1'b1; waddr = a; wdata = d;
    @(posedge clk); #1;
    wr = 1'b0;
  endtask

  function automatic logic [7:0] rreg(input logic [1:0] a);
    raddr = a;
    return rdata;
  endfunction

  task automatic rchk(input string r, input logic [1:0] a, input logic [7:0] e);
    raddr = a; #1;
    check(r, rdata, e);
  endtask

  // driver: push expected return address, then let the design take it
  task automatic expect_take(input logic [PCW-1:0] cur_pc);
    pc = cur_pc;
    exp_q.push_back(cur_pc + 13'd1);
  endtask

  task automatic wait_pin_flag(input string r, input bit should_set);
    bit seen = 0;
    for (int i = 0; i < 20; i++) begin
      tick(1);
      raddr = 2'd0; #1;
      if (!seen && rdata[1]) begin
        seen = 1;
        // ph still holds the phase of the edge just passed
        n_tests++;
        if (!(ph == 2'd3 || ph == 2'd0)) begin
          n_fail++;
          $display("FAIL R4: pin flag set in phase %0d, expected 3 or 0", ph);
        end
      end
    end
    check(r, seen, should_set);
  endtask

  initial begin
    #2_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int d0, v0, a0;
    tick(3);
    // R1 reset state
    rchk("R1 ctrl", 2'd0, 8'h00);
    rchk("R1 pflag", 2'd1, 8'h00);
    rchk("R1 pen", 2'd2, 8'h00);
    check("R1 outputs", {ack, dummy, vfetch}, 3'b000);
    rst_n = 1'b1;
    tick(2);

    // R2 register map
    wreg(2'd2, 8'hA5);
    rchk("R2 pen readback", 2'd2, 8'hA5);
    wreg(2'd0, 8'h18);
    rchk("R2 ctrl readback", 2'd0, 8'h18);
    rchk("R2 unused address", 2'd3, 8'h00);
    wreg(2'd2, 8'h00);
    wreg(2'd0, 8'h00);

    // R9 peripheral pulse sets matching bit
    @(posedge clk); #1; pev = 8'h20; tick(1); pev = 8'h00;
    rchk("R9 pflag bit5", 2'd1, 8'h20);
    // R3 sticky, sw clear, hw set wins
    tick(5);
    rchk("R3 sticky", 2'd1, 8'h20);
    wreg(2'd1, 8'h00);
    rchk("R3 sw clear", 2'd1, 8'h00);
    @(posedge clk); #1;
    wr = 1'b1; waddr = 2'd1; wdata = 8'h00; pev = 8'h01;
    tick(1);
    wr = 1'b0; pev = 8'h00;
    rchk("R3 hw set beats clear", 2'd1, 8'h01);
    wreg(2'd1, 8'h00);

    // R10 timer and port-change pulses
    @(posedge clk); #1; tmr = 1'b1; tick(1); tmr = 1'b0;
    rchk("R10 timer flag", 2'd0, 8'h04);
    @(posedge clk); #1; pchg = 1'b1; tick(1); pchg = 1'b0;
    rchk("R10 port flag", 2'd0, 8'h05);
    wreg(2'd0, 8'h00);

    // R4 pin edges with polarity select and window
    rise_sel = 1'b1;
    pin = 1'b1;
    wait_pin_flag("R4 rising sets", 1'b1);
    wreg(2'd0, 8'h00);
    tick(1); pin = 1'b0;
    wait_pin_flag("R4 falling ignored in rise mode", 1'b0);
    rise_sel = 1'b0;
    tick(3); pin = 1'b1;
    wait_pin_flag("R4 rising ignored in fall mode", 1'b0);
    tick(2); pin = 1'b0;
    wait_pin_flag("R4 falling sets", 1'b1);
    wreg(2'd0, 8'h00);
    check("R4 no ack with GIE off", n_ack, 0);

    // R5/R6/R7 timer source taken
    d0 = n_dummy; v0 = n_vec;
    expect_take(13'h0123);
    wreg(2'd0, 8'hA0);
    @(posedge clk); #1; tmr = 1'b1; tick(1); tmr = 1'b0;
    tick(24);
    check("R6 one ack", n_ack, 1);
    check("R7 dummy clocks", n_dummy - d0, 8);
    check("R7 vector clocks", n_vec - v0, 4);
    rchk("R6 GIE cleared", 2'd0, 8'h24);
    wreg(2'd0, 8'h20);
    @(posedge clk); #1; reti = 1'b1; tick(1); reti = 1'b0;
    rchk("R8 reti sets GIE", 2'd0, 8'hA0);
    tick(12);
    check("R5 no ack without flag", n_ack, 1);

    // R5 peripheral path gated by peripheral enable
    wreg(2'd0, 8'h00);
    wreg(2'd2, 8'h02);
    @(posedge clk); #1; pev = 8'h02; tick(1); pev = 8'h00;
    wreg(2'd0, 8'h80);
    tick(12);
    check("R5 peripheral enable off", n_ack, 1);
    check("R5 req low", req, 1'b0);
    a0 = n_ack;
    expect_take(13'h1FFF);
    wreg(2'd0, 8'hC0);
    tick(24);
    check("R6 peripheral ack with wrap", n_ack - a0, 1);
    check("R6 scoreboard drained", exp_q.size(), 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule